// File: doc/BRIEF.md
# Bit Permute Doubleword Unit

This is a 64-bit integer execution unit for a bit-gather operation. Each issued operation carries an instruction word and two 64-bit operands: a selector word and a data word. The selector holds eight byte-wide indices. Each index picks one bit of the data word, and the eight picked bits form the low byte of the 64-bit result. The result depends only on the two operands and reads no other state.

The unit checks the instruction word against the expected primary opcode, extended opcode and record-bit encoding. A non-matching word still produces a response, but that response carries an illegal flag and a zero result.

Operations enter and leave through valid/ready streams with a single registered output stage. An operation is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. The response stays on the output, unchanged, until a rising edge where `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output stage is empty or is being drained in that same cycle.

Top module: `bitgather_unit`

## Requirements
- R1: Selector byte i, at bits [8i+7:8i] counting from the LSB, holds index k. When k is below 64, result bit i equals data bit (63 - k) in LSB-0 numbering, so index 0 selects the data MSB and index 63 selects the data LSB.
- R2: When a selector byte holds a value from 64 to 255, the corresponding result bit is 0.
- R3: Result bits 63 down to 8 are always 0.
- R4: An instruction word is legal when bits [31:26] equal 31, bits [10:1] equal 252 and bit 0 is 0. Bits [25:11] have no effect on the response.
- R5: For an illegal instruction word, the response has `out_illegal` = 1 and `out_result` = 0. For a legal word, `out_illegal` = 0.
- R6: An operation accepted on a rising edge appears with `out_valid` = 1 immediately after that edge. After a rising edge where the output is drained and no new operation is accepted, `out_valid` is 0.
- R7: While `out_valid` = 1 and `out_ready` = 0, `out_valid`, `out_result` and `out_illegal` hold their values.
- R8: `in_ready` equals (not `out_valid`) or `out_ready`.
- R9: While `rst_n` is low, `out_valid`, `out_illegal` and `out_result` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit can accept an operation |
| in_insn | input | 32 | Instruction word |
| in_sel | input | 64 | Selector word (eight byte indices) |
| in_data | input | 64 | Data word to gather from |
| out_valid | output | 1 | A response is held |
| out_ready | input | 1 | Downstream accepts the response |
| out_result | output | 64 | Gathered result |
| out_illegal | output | 1 | The instruction word did not decode |

## Verification
The bench aims at the index edges:
- Index 0 and index 63 catch a design that numbers data bits from the LSB, because it would return the wrong end of the data word.
- Indices of 64 and above catch a design that drops the upper index bits, because it would wrap to a real data bit instead of returning zero.
- Mixed selectors catch lane-order mistakes, because a swap would place gathered bits in the wrong result positions.

Instruction words that miss by one field, or that differ only in the record bit, catch a loose decoder that would report illegal operations as legal. Random stalls on `out_ready` catch an output stage that overwrites or drops a held response.

// File: rtl/bitgather_pkg.sv
package bitgather_pkg;
  localparam int unsigned WORD_W    = 64;
  localparam int unsigned FIELD_W   = 8;
  localparam int unsigned INSN_W    = 32;
  localparam int unsigned OPC_LSB   = 26;
  localparam int unsigned OPC_W     = 6;
  localparam int unsigned XO_LSB    = 1;
  localparam int unsigned XO_W      = 10;
  localparam int unsigned RC_BIT    = 0;
  localparam logic [5:0]  PRIMARY_OP = 6'd31;
  localparam logic [9:0]  EXT_OP     = 10'd252;
endpackage

// File: rtl/bitgather_decode.sv
module bitgather_decode
  import bitgather_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output logic              legal
);
  localparam int unsigned REG_LSB = XO_LSB + XO_W;
  localparam int unsigned REG_MSB = OPC_LSB - 1;

  logic opc_hit, xo_hit, rc_clear;
  logic unused_regfields;

  assign opc_hit  = insn[OPC_LSB +: OPC_W] == PRIMARY_OP;
  assign xo_hit   = insn[XO_LSB +: XO_W] == EXT_OP;
  assign rc_clear = ~insn[RC_BIT];
  // register specifier fields are routed elsewhere in the pipeline
  assign unused_regfields = ^insn[REG_MSB:REG_LSB];
  assign legal = opc_hit & xo_hit & rc_clear;
endmodule

// File: rtl/bitgather_lane.sv
module bitgather_lane #(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned FIELD_W = 8
) (
  input  logic [DATA_W-1:0]  data,
  input  logic [FIELD_W-1:0] idx,
  output logic               bit_o
);
  localparam int unsigned POS_W = $clog2(DATA_W);

  logic [DATA_W-1:0] msb_first;
  logic              in_range;

  always_comb begin
    for (int k = 0; k < DATA_W; k++) begin
      msb_first[k] = data[DATA_W-1-k];
    end
  end

  assign in_range = 32'(idx) < 32'(DATA_W);
  assign bit_o    = in_range & msb_first[idx[POS_W-1:0]];
endmodule

// File: rtl/bitgather_array.sv
module bitgather_array #(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned FIELD_W = 8
) (
  input  logic [DATA_W-1:0] sel,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] gathered
);
  localparam int unsigned LANES = DATA_W / FIELD_W;

  logic [LANES-1:0] lane_bits;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bitgather_lane #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_lane (
      .data  (data),
      .idx   (sel[g*FIELD_W +: FIELD_W]),
      .bit_o (lane_bits[g])
    );
  end

  always_comb begin
    gathered = '0;
    gathered[LANES-1:0] = lane_bits;
  end
endmodule

// File: rtl/bitgather_outreg.sv
module bitgather_outreg #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_valid,
  input  logic [DATA_W-1:0] load_result,
  input  logic              load_illegal,
  output logic              load_ready,
  output logic              q_valid,
  input  logic              q_ready,
  output logic [DATA_W-1:0] q_result,
  output logic              q_illegal
);
  assign load_ready = ~q_valid | q_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid   <= 1'b0;
      q_result  <= '0;
      q_illegal <= 1'b0;
    end else if (load_ready) begin
      q_valid <= load_valid;
      if (load_valid) begin
        q_result  <= load_result;
        q_illegal <= load_illegal;
      end
    end
  end
endmodule

// File: rtl/bitgather_unit.sv
module bitgather_unit
  import bitgather_pkg::*;
#(
  parameter int unsigned DATA_W  = WORD_W,
  parameter int unsigned FIELD_W = bitgather_pkg::FIELD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INSN_W-1:0] in_insn,
  input  logic [DATA_W-1:0] in_sel,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_illegal
);
  logic              legal;
  logic [DATA_W-1:0] gathered;
  logic [DATA_W-1:0] next_result;

  bitgather_decode u_decode (
    .insn  (in_insn),
    .legal (legal)
  );

  bitgather_array #(.DATA_W(DATA_W), .FIELD_W(FIELD_W)) u_array (
    .sel      (in_sel),
    .data     (in_data),
    .gathered (gathered)
  );

  assign next_result = legal ? gathered : '0;

  bitgather_outreg #(.DATA_W(DATA_W)) u_outreg (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_valid   (in_valid),
    .load_result  (next_result),
    .load_illegal (~legal),
    .load_ready   (in_ready),
    .q_valid      (out_valid),
    .q_ready      (out_ready),
    .q_result     (out_result),
    .q_illegal    (out_illegal)
  );
endmodule

// File: rtl/bitgather_checker.sv
module bitgather_checker #(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic              out_illegal
);
  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_result[DATA_W-1:8] == '0);

  assert_illegal_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_illegal) |-> out_result == '0);

  assert_accept_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_drain_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_result) && $stable(out_illegal)));

  assert_stall_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

bind bitgather_unit bitgather_checker #(.DATA_W(DATA_W)) u_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_result  (out_result),
  .out_illegal (out_illegal)
);

// File: tb/bitgather_unit_bench.sv
module bitgather_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_insn = '0;
  logic [63:0] in_sel = '0;
  logic [63:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_result;
  logic        out_illegal;

  int vectors = 0;
  int fails = 0;
  int cycles = 0;

  // model state
  logic        m_valid = 1'b0;
  logic [63:0] m_res = '0;
  logic        m_ill = 1'b0;

  always #5 clk = ~clk;

  bitgather_unit u_bitgather_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .in_sel(in_sel), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_illegal(out_illegal)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired: cycles %0d expected below 150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  function automatic logic [63:0] ref_gather(logic [63:0] s, logic [63:0] d);
    logic [63:0] r = '0;
    for (int i = 0; i < 8; i++) begin
      int k = int'(s[i*8 +: 8]);
      if (k < 64) r[i] = d[63-k];
    end
    return r;
  endfunction

  function automatic logic ref_legal(logic [31:0] w);
    return (w[31:26] == 6'd31) && (w[10:1] == 10'd252) && !w[0];
  endfunction

  function automatic logic [31:0] good_insn();
    logic [14:0] regs = 15'($urandom);
    return {6'd31, regs, 10'd252, 1'b0};
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one cycle at the falling edge, predict, then compare after the next rising edge
  task automatic step(logic v, logic [31:0] w, logic [63:0] s, logic [63:0] d,
                      logic ordy, string tag);
    logic stalled;
    in_valid = v; in_insn = w; in_sel = s; in_data = d; out_ready = ordy;
    #1;
    check("R8 in_ready", 64'(in_ready), 64'(!m_valid || ordy));
    stalled = m_valid && !ordy;
    if (!m_valid || ordy) begin
      if (v) begin
        m_valid = 1'b1;
        m_ill   = !ref_legal(w);
        m_res   = m_ill ? 64'h0 : ref_gather(s, d);
      end else begin
        m_valid = 1'b0;
      end
    end
    @(negedge clk);
    check(stalled ? "R7 hold valid" : "R6 valid", 64'(out_valid), 64'(m_valid));
    if (m_valid) begin
      check(stalled ? "R7 hold illegal" : (m_ill ? "R5 illegal" : "R4 legal"),
            64'(out_illegal), 64'(m_ill));
      check(stalled ? "R7 hold result" : tag, out_result, m_res);
      check("R3 upper bits", {8'h0, out_result[63:8]}, 64'h0);
    end
  endtask

  initial begin
    logic [63:0] s;
    logic [63:0] d;
    // reset: garbage offered while reset is held
    in_valid = 1'b1; in_insn = good_insn(); in_sel = 64'h0; in_data = '1; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 reset valid", 64'(out_valid), 64'h0);
    check("R9 reset illegal", 64'(out_illegal), 64'h0);
    check("R9 reset result", out_result, 64'h0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // R1: all indices 0 pick the MSB
    step(1, good_insn(), 64'h0, 64'h8000_0000_0000_0000, 1, "R1 idx0 msb set");
    step(1, good_insn(), 64'h0, 64'h7FFF_FFFF_FFFF_FFFF, 1, "R1 idx0 msb clear");
    // R1: all indices 63 pick the LSB
    step(1, good_insn(), 64'h3F3F_3F3F_3F3F_3F3F, 64'h0000_0000_0000_0001, 1, "R1 idx63 lsb set");
    step(1, good_insn(), 64'h3F3F_3F3F_3F3F_3F3F, 64'hFFFF_FFFF_FFFF_FFFE, 1, "R1 idx63 lsb clear");
    // R2: indices 64..255 yield zero
    for (int b = 64; b < 256; b += 8) begin
      s = {8{8'(b)}};
      step(1, good_insn(), s, '1, 1, "R2 out of range");
    end
    step(1, good_insn(), {8{8'hFF}}, '1, 1, "R2 index 255");
    step(1, good_insn(), {8{8'h40}}, '1, 1, "R2 index 64");
    // R1 R2 mix, lane order distinct
    step(1, good_insn(), 64'h80_3F_41_00_C0_07_40_01, '1, 1, "R1 R2 mixed");
    step(1, good_insn(), 64'h07_06_05_04_03_02_01_00, 64'hA5C3_0000_0000_0000, 1, "R1 lane order");
    // R5: near-miss encodings
    step(1, {6'd30, 15'h0, 10'd252, 1'b0}, 64'h0, '1, 1, "R5 bad opcode");
    step(1, {6'd31, 15'h0, 10'd253, 1'b0}, 64'h0, '1, 1, "R5 bad ext opcode");
    step(1, {6'd31, 15'h0, 10'd252, 1'b1}, 64'h0, '1, 1, "R5 record bit");
    // R4: register fields ignored
    step(1, {6'd31, 15'h7FFF, 10'd252, 1'b0}, 64'h0, '1, 1, "R4 regs ones");
    step(1, {6'd31, 15'h0000, 10'd252, 1'b0}, 64'h0, '1, 1, "R4 regs zero");
    // R6 R7: idle and stall sequences
    step(0, good_insn(), 64'h0, '1, 1, "R6 idle");
    step(1, good_insn(), 64'h0, '1, 0, "R7 load before stall");
    step(1, good_insn(), 64'h3F, 64'h1, 0, "R7 stalled");
    step(1, good_insn(), 64'h3F, 64'h1, 0, "R7 stalled");
    step(0, good_insn(), 64'h0, 64'h0, 1, "R6 drain");
    // random traffic with back-pressure
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] w;
      for (int i = 0; i < 8; i++) s[i*8 +: 8] = 8'($urandom_range(0, 95));
      d = {$urandom, $urandom};
      w = ($urandom_range(0, 7) == 0) ? $urandom : good_insn();
      step($urandom_range(0, 3) != 0, w, s, d, $urandom_range(0, 3) != 0, "R1 R2 random");
    end
    step(0, 32'h0, 64'h0, 64'h0, 1, "R6 final drain");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule